// File: doc/BRIEF.md
# Column-Suppressing Frame Serialiser

This block turns one frame of a pixel array into a single-bit stream. It fetches pixel words one at a time through a request/response port and shifts each word out MSB first. It also emits a valid strobe and markers for the start and end of the frame. The array is organised as columns of rows. A frame begins when `start` is seen while the block is idle. The mode, the pixel width and the per-column hit flags are captured at that moment, and later changes to them have no effect on the frame in progress.

In full-frame mode every pixel of every column is sent, whether it was hit or not. In suppressed mode the block first sends a column map with one bit per column, column 0 first. It then sends only the columns whose map bit is set. The frame always carries at least a minimum number of columns. If too few columns were hit, the lowest-indexed columns without hits are added, and their map bits are set so that the header describes exactly the columns that follow.

Top module: `zcs_frame_ser`

## Requirements
- R1: In full-frame mode (`zcs_en`=0) no header is sent, and every column is sent in ascending index order. Within a column the rows go in ascending order, and each pixel goes MSB first.
- R2: `bpp_sel` selects the bits sent per pixel: 0 gives 4, 1 gives 10, 2 gives 14 and 3 gives 28. The bits sent are the low bits of `pix_word`, most significant first.
- R3: In suppressed mode (`zcs_en`=1) the frame opens with NUM_COLS map bits, column 0 first, before any pixel bit.
- R4: In suppressed mode only columns whose map bit is 1 are sent after the header. They go in ascending order, each with all of its rows.
- R5: If fewer than MIN_COLS columns are flagged, the lowest-indexed unflagged columns are added until MIN_COLS columns are sent, and their map bits read 1.
- R6: If MIN_COLS or more columns are flagged, the map equals the captured hit flags and no column is added.
- R7: `frame_start` is high for exactly one cycle, together with the first valid bit of the frame.
- R8: `frame_end` is high together with the last pixel bit of the frame. `busy` falls in the next cycle.
- R9: `ser_valid` is high only in cycles that present a frame bit. A read request keeps `rd_req`, `rd_col` and `rd_row` steady until `rd_ready` accepts it.
- R10: `start`, `zcs_en`, `bpp_sel` and `col_hit` are ignored while `busy` is high.
- R11: After reset the block is idle, with `busy`, `ser_valid`, `rd_req`, `frame_start` and `frame_end` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a frame (used only when idle) |
| zcs_en | input | 1 | 1 = column suppression, 0 = full frame |
| bpp_sel | input | 2 | Pixel width code: 4/10/14/28 bits |
| col_hit | input | NUM_COLS | Per-column hit flags |
| rd_ready | input | 1 | Pixel store accepts the read request |
| pix_valid | input | 1 | Requested pixel word is present |
| pix_word | input | 28 | Pixel word, low bits used |
| rd_req | output | 1 | Read request for one pixel |
| rd_col | output | COL_W | Column of the requested pixel |
| rd_row | output | ROW_W | Row of the requested pixel |
| ser_data | output | 1 | Serial bit |
| ser_valid | output | 1 | ser_data carries a frame bit |
| frame_start | output | 1 | First bit of the frame |
| frame_end | output | 1 | Last bit of the frame |
| busy | output | 1 | A frame is in progress |

## Verification
The directed cases cover suppressed frames with no hits, with one hit short of the minimum, with exactly the minimum and with every column flagged. A design that padded with the wrong columns, or left the padded columns out of the map, would send a header that does not match the columns that follow. Every pixel width is run in both modes under random fetch latency. An off-by-one in the bit counter would stretch or clip each pixel and shift the entire stream. A second `start` is pulsed mid-frame while the mode, width and hit inputs are changed. A design that re-sampled them would corrupt the remaining bits or restart the header.

// File: rtl/zcs_pkg.sv
// Shared types and helpers for the column-suppressing frame serialiser.
// Assumes pixel words are at most 28 bits wide.
package zcs_pkg;

    localparam int PIX_W = 28;
    localparam int BITS_W = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_REQ,
        ST_WAIT,
        ST_SHIFT
    } ser_state_t;

    // Map the 2-bit width code to a bit count per pixel.
    function automatic logic [BITS_W-1:0] bpp_bits(input logic [1:0] sel);
        case (sel)
            2'd0:    return 5'd4;
            2'd1:    return 5'd10;
            2'd2:    return 5'd14;
            default: return 5'd28;
        endcase
    endfunction

endpackage

// File: rtl/zcs_map_pad.sv
// Builds the outgoing column map from the raw hit flags. Columns that were
// hit keep their bit. If fewer than MIN_COLS are hit, the lowest-indexed
// unhit columns are added until MIN_COLS bits are set.
// Assumes MIN_COLS <= NUM_COLS. The logic is purely combinational.
module zcs_map_pad #(
    parameter int NUM_COLS = 256,
    parameter int MIN_COLS = 16,
    localparam int CNT_W = $clog2(NUM_COLS + 1)
) (
    input  logic [NUM_COLS-1:0] hits,
    output logic [NUM_COLS-1:0] map
);

    logic [CNT_W-1:0] hit_cnt;
    logic [CNT_W-1:0] deficit;
    logic [CNT_W-1:0] zeros;

    // Count the hit columns and work out how many must be added.
    always_comb begin
        hit_cnt = '0;
        for (int i = 0; i < NUM_COLS; i++) begin
            hit_cnt = hit_cnt + CNT_W'(hits[i]);
        end
        deficit = (hit_cnt >= CNT_W'(MIN_COLS)) ? '0 : CNT_W'(MIN_COLS) - hit_cnt;
    end

    // Walk upward and add unhit columns while a deficit remains.
    always_comb begin
        zeros = '0;
        map   = '0;
        for (int i = 0; i < NUM_COLS; i++) begin
            if (hits[i]) begin
                map[i] = 1'b1;
            end else begin
                map[i] = (zeros < deficit);
                zeros  = zeros + 1'b1;
            end
        end
    end

endmodule

// File: rtl/zcs_first_set.sv
// Returns the index of the lowest set bit of a vector, or 0 if none is set.
// Combinational priority encoder. The caller knows whether the vector is empty.
module zcs_first_set #(
    parameter int N = 256,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so that the lowest set bit is written last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/zcs_pix_shift.sv
// Holds one pixel word and presents its low `width` bits MSB first,
// one bit per `advance`. last_bit marks the final bit of the word.
// Assumes width is not 0 and not larger than WORD_W.
module zcs_pix_shift #(
    parameter int WORD_W = 28,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  width,
    input  logic              advance,
    output logic              bit_out,
    output logic              last_bit
);

    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  left_q;
    logic [CNT_W-1:0]  pos;

    // Capture a new word, or count down the bits still to send.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            left_q <= '0;
        end else if (load) begin
            word_q <= word;
            left_q <= width;
        end else if (advance && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    // Select the current bit position.
    always_comb begin
        pos      = left_q - 1'b1;
        bit_out  = (left_q != '0) ? word_q[pos] : 1'b0;
        last_bit = (left_q == CNT_W'(1));
    end

endmodule

// File: rtl/zcs_frame_ser.sv
// Frame serialiser with optional column suppression. On `start` while idle
// it captures the mode, the pixel width and the padded column map. In
// suppressed mode it sends the map, then fetches and shifts out every pixel
// of each selected column in ascending order.
// Assumes the pixel store answers a request with pix_valid no earlier than
// one cycle after the request is accepted.
module zcs_frame_ser
    import zcs_pkg::*;
#(
    parameter int NUM_COLS = 256,
    parameter int NUM_ROWS = 256,
    parameter int MIN_COLS = 16,
    localparam int COL_W = $clog2(NUM_COLS),
    localparam int ROW_W = $clog2(NUM_ROWS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                zcs_en,
    input  logic [1:0]          bpp_sel,
    input  logic [NUM_COLS-1:0] col_hit,
    input  logic                rd_ready,
    input  logic                pix_valid,
    input  logic [27:0]         pix_word,
    output logic                rd_req,
    output logic [COL_W-1:0]    rd_col,
    output logic [ROW_W-1:0]    rd_row,
    output logic                ser_data,
    output logic                ser_valid,
    output logic                frame_start,
    output logic                frame_end,
    output logic                busy
);

    ser_state_t          state_q;
    logic [NUM_COLS-1:0] map_q;
    logic [NUM_COLS-1:0] rem_q;
    logic [COL_W-1:0]    hdr_idx_q;
    logic [ROW_W-1:0]    row_q;
    logic [BITS_W-1:0]   width_q;
    logic                first_q;

    logic [NUM_COLS-1:0] padded_map;
    logic [COL_W-1:0]    cur_col;
    logic [NUM_COLS-1:0] cur_oh;
    logic [NUM_COLS-1:0] rem_after;
    logic                shift_bit;
    logic                shift_last;
    logic                load_word;
    logic                in_shift;
    logic                row_last;

    zcs_map_pad #(.NUM_COLS(NUM_COLS), .MIN_COLS(MIN_COLS)) u_pad (
        .hits (col_hit),
        .map  (padded_map)
    );

    zcs_first_set #(.N(NUM_COLS)) u_first (
        .vec (rem_q),
        .idx (cur_col)
    );

    zcs_pix_shift #(.WORD_W(PIX_W), .CNT_W(BITS_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_word),
        .word     (pix_word),
        .width    (width_q),
        .advance  (in_shift),
        .bit_out  (shift_bit),
        .last_bit (shift_last)
    );

    // Decode column bookkeeping and the shifter controls.
    always_comb begin
        cur_oh    = {{(NUM_COLS-1){1'b0}}, 1'b1} << cur_col;
        rem_after = rem_q & ~cur_oh;
        row_last  = (row_q == ROW_W'(NUM_ROWS - 1));
        in_shift  = (state_q == ST_SHIFT);
        load_word = (state_q == ST_WAIT) && pix_valid;
    end

    // Frame sequencing: header, then request/wait/shift for each pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            map_q     <= '0;
            rem_q     <= '0;
            hdr_idx_q <= '0;
            row_q     <= '0;
            width_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        map_q     <= zcs_en ? padded_map : '1;
                        rem_q     <= zcs_en ? padded_map : '1;
                        width_q   <= bpp_bits(bpp_sel);
                        hdr_idx_q <= '0;
                        row_q     <= '0;
                        state_q   <= zcs_en ? ST_HDR : ST_REQ;
                    end
                end
                ST_HDR: begin
                    hdr_idx_q <= hdr_idx_q + 1'b1;
                    if (hdr_idx_q == COL_W'(NUM_COLS - 1)) state_q <= ST_REQ;
                end
                ST_REQ: begin
                    if (rd_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (pix_valid) state_q <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (shift_last) begin
                        if (row_last) begin
                            row_q   <= '0;
                            rem_q   <= rem_after;
                            state_q <= (rem_after == '0) ? ST_IDLE : ST_REQ;
                        end else begin
                            row_q   <= row_q + 1'b1;
                            state_q <= ST_REQ;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Track whether the next valid bit is the first of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            first_q <= 1'b1;
        end else if (ser_valid) begin
            first_q <= 1'b0;
        end
    end

    // Drive the serial outputs, the markers and the fetch port.
    always_comb begin
        busy        = (state_q != ST_IDLE);
        ser_valid   = (state_q == ST_HDR) || in_shift;
        ser_data    = (state_q == ST_HDR) ? map_q[hdr_idx_q] : (in_shift & shift_bit);
        frame_start = ser_valid && first_q;
        frame_end   = in_shift && shift_last && row_last && (rem_after == '0);
        rd_req      = (state_q == ST_REQ);
        rd_col      = cur_col;
        rd_row      = row_q;
    end

endmodule

// File: rtl/zcs_frame_ser_chk.sv
// Protocol checks for zcs_frame_ser, attached to every instance by bind.
module zcs_frame_ser_chk #(
    parameter int COL_W = 8,
    parameter int ROW_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             ser_valid,
    input logic             frame_start,
    input logic             frame_end,
    input logic             rd_req,
    input logic             rd_ready,
    input logic [COL_W-1:0] rd_col,
    input logic [ROW_W-1:0] rd_row
);

    // R7
    start_marks_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> ser_valid);

    // R7
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R8
    end_marks_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> ser_valid);

    // R8
    end_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !busy);

    // R8
    idle_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(frame_end));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ready) |=> (rd_req && $stable(rd_col) && $stable(rd_row)));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ser_valid && !rd_req && !frame_end));

endmodule

bind zcs_frame_ser zcs_frame_ser_chk #(.COL_W(COL_W), .ROW_W(ROW_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .ser_valid   (ser_valid),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .rd_req      (rd_req),
    .rd_ready    (rd_ready),
    .rd_col      (rd_col),
    .rd_row      (rd_row)
);

// File: tb/sim_zcs_frame_ser.sv
`timescale 1ns/1ps
module sim_zcs_frame_ser;

    localparam int NC = 32;
    localparam int NR = 3;
    localparam int MC = 16;
    localparam int CW = $clog2(NC);
    localparam int RW = $clog2(NR);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          zcs_en = 1'b0;
    logic [1:0]    bpp_sel = 2'd0;
    logic [NC-1:0] col_hit = '0;
    logic          rd_ready = 1'b0;
    logic          pix_valid = 1'b0;
    logic [27:0]   pix_word = '0;
    logic          rd_req, ser_data, ser_valid, frame_start, frame_end, busy;
    logic [CW-1:0] rd_col;
    logic [RW-1:0] rd_row;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [27:0] salt = 28'h5A5_1234;

    bit got[$];
    bit exp_q[$];
    int fs_pos[$];
    int fe_pos[$];

    always #4 clk = ~clk;

    zcs_frame_ser #(.NUM_COLS(NC), .NUM_ROWS(NR), .MIN_COLS(MC)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .zcs_en(zcs_en), .bpp_sel(bpp_sel),
        .col_hit(col_hit), .rd_ready(rd_ready), .pix_valid(pix_valid), .pix_word(pix_word),
        .rd_req(rd_req), .rd_col(rd_col), .rd_row(rd_row), .ser_data(ser_data),
        .ser_valid(ser_valid), .frame_start(frame_start), .frame_end(frame_end), .busy(busy)
    );

    function automatic logic [27:0] pix_fn(input int c, input int r, input logic [27:0] s);
        return (28'(c) * 28'h0A5_3C1 + 28'(r) * 28'h0013_57 + s) ^ (28'(r) << 9);
    endfunction

    function automatic int width_of(input logic [1:0] sel);
        case (sel)
            2'd0: return 4;
            2'd1: return 10;
            2'd2: return 14;
            default: return 28;
        endcase
    endfunction

    function automatic logic [NC-1:0] model_map(input logic [NC-1:0] h);
        logic [NC-1:0] m = h;
        int n = 0;
        for (int i = 0; i < NC; i++) n += int'(h[i]);
        for (int i = 0; i < NC; i++) begin
            if (n < MC && !h[i]) begin
                m[i] = 1'b1;
                n++;
            end
        end
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Pixel store model: random accept delay and random response latency.
    initial begin
        forever begin
            @(negedge clk);
            pix_valid = 1'b0;
            if (rd_req && ($urandom % 3) != 0) begin
                automatic int c = int'(rd_col);
                automatic int r = int'(rd_row);
                rd_ready = 1'b1;
                @(negedge clk);
                rd_ready = 1'b0;
                repeat ($urandom % 3) @(negedge clk);
                pix_word  = pix_fn(c, r, salt);
                pix_valid = 1'b1;
            end
        end
    end

    // Output collector, sampled on the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (ser_valid) begin
                if (frame_start) fs_pos.push_back(got.size());
                if (frame_end) fe_pos.push_back(got.size());
                got.push_back(ser_data);
            end else if (frame_start || frame_end) begin
                fs_pos.push_back(-1);
            end
        end
    end

    task automatic run_frame(input bit zm, input logic [1:0] bs, input logic [NC-1:0] h,
                             input bit disturb);
        logic [NC-1:0] m;
        int w, bad, first_bad, cyc;
        string rq;
        m = zm ? model_map(h) : '1;
        w = width_of(bs);
        exp_q.delete();
        if (zm) for (int i = 0; i < NC; i++) exp_q.push_back(m[i]);
        for (int c = 0; c < NC; c++) begin
            if (m[c]) begin
                for (int r = 0; r < NR; r++) begin
                    logic [27:0] pw = pix_fn(c, r, salt);
                    for (int b = w - 1; b >= 0; b--) exp_q.push_back(pw[b]);
                end
            end
        end
        @(negedge clk);
        got.delete(); fs_pos.delete(); fe_pos.delete();
        zcs_en = zm; bpp_sel = bs; col_hit = h; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            repeat (6) @(negedge clk);
            // R10: a second start and new settings while busy must be ignored
            start = 1'b1; zcs_en = ~zm; bpp_sel = bs + 2'd1; col_hit = ~h;
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (busy && cyc < 40000) begin
            @(negedge clk);
            cyc++;
        end
        @(negedge clk);
        rq = zm ? "R4" : "R1";
        // R9: valid cycles equal the number of frame bits
        check(got.size() == exp_q.size(), "R9", "bit count", got.size(), exp_q.size());
        bad = 0; first_bad = -1;
        for (int i = 0; i < exp_q.size() && i < got.size(); i++) begin
            if (got[i] != exp_q[i]) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        end
        check(bad == 0, disturb ? "R10" : rq, "stream mismatches (first index)", first_bad, -1);
        // R2: width-dependent payload checked through the stream above; record the width case
        check(bad == 0 && got.size() == exp_q.size(), "R2", "pixel width code", bs, bs);
        if (zm) begin
            int hb = 0;
            for (int i = 0; i < NC && i < got.size(); i++) if (got[i] != m[i]) hb++;
            if (model_map(h) == h) check(hb == 0, "R6", "header vs hits", hb, 0);
            else check(hb == 0, "R5", "padded header", hb, 0);
            check(hb == 0, "R3", "header bits", hb, 0);
        end
        check(fs_pos.size() == 1 && fs_pos[0] == 0, "R7", "frame_start position",
              fs_pos.size() > 0 ? fs_pos[0] : -2, 0);
        check(fe_pos.size() == 1 && fe_pos[0] == exp_q.size() - 1, "R8", "frame_end position",
              fe_pos.size() > 0 ? fe_pos[0] : -2, exp_q.size() - 1);
        check(!busy, "R8", "busy after frame", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NC-1:0] h;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!busy && !ser_valid && !rd_req && !frame_start && !frame_end, "R11",
              "reset outputs", {busy, ser_valid, rd_req, frame_start, frame_end}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed cases
        for (int b = 0; b < 4; b++) run_frame(1'b0, 2'(b), '0, 1'b0);
        run_frame(1'b1, 2'd0, '0, 1'b0);
        h = '0; for (int i = 0; i < MC - 1; i++) h[NC - 1 - 2 * i] = 1'b1;
        run_frame(1'b1, 2'd1, h, 1'b0);
        h = '0; for (int i = 0; i < MC; i++) h[2 * i + 1] = 1'b1;
        run_frame(1'b1, 2'd2, h, 1'b0);
        run_frame(1'b1, 2'd3, '1, 1'b0);
        run_frame(1'b1, 2'd0, 32'h8000_0001, 1'b1);
        run_frame(1'b0, 2'd1, 32'h0F0F_0F0F, 1'b1);
        // Random frames
        for (int k = 0; k < 10; k++) begin
            h = NC'($urandom) & NC'($urandom);
            salt = 28'($urandom);
            run_frame(1'($urandom), 2'($urandom), h, 1'(k % 3 == 0));
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule